// File: doc/BRIEF.md
# Parallel FPGA Configuration Master

This block loads a bitstream into a slave FPGA over its byte-wide or word-wide parallel configuration port. A host pulses `start` with the payload length, the bus width, the reset hold time and the clock phase length. The block then selects the target for writing, holds the target's program line low for the requested time, waits for the init line to come back high, and moves the payload across. Payload bytes arrive on a valid/ready stream.

Each bus word is placed on the data lines with every byte in reversed bit order. It is then clocked in with exactly one configuration clock pulse, and each clock phase lasts a programmable number of system clocks. After the last word the block checks the init line for a configuration error and polls the done line for a bounded number of cycles. If done is seen, it issues eight trailing clock pulses so that the target can finish its startup. The outcome is success or failure with a reason code, and it stays visible until the next start.

Top module: `pcfg_master`

## Requirements
- R1: After reset `busy`, `ok`, `fail` and `s_ready` are 0, `fail_code` is 0, `cfg_cclk` is low, `cfg_d` is zero and `cfg_prog_n`, `cfg_cs_n` and `cfg_rdwr_n` are all high.
- R2: `width_sel` = 1 selects 8-bit words and 2 selects 16-bit words. A start with any other value raises `fail` with `fail_code` = 1 on the next cycle. It never raises `busy`, never selects the target, never pulses the program line and takes no bytes.
- R3: `cfg_cs_n` and `cfg_rdwr_n` go low, with `cfg_prog_n` still high, at least one cycle before `cfg_prog_n` falls.
- R4: `cfg_prog_n` stays low for exactly max(`hold_cycles`, 1) system clocks and then returns high.
- R5: No configuration clock edge and no byte transfer happens while the program line is low, or before `cfg_init_n` has been seen high after the reset pulse.
- R6: Each data word gets exactly one `cfg_cclk` pulse. The high phase lasts exactly max(`phase_cycles`, 1) clocks, every low phase between pulses lasts at least that long, and `cfg_d` does not change while `cfg_cclk` is high.
- R7: In 8-bit mode, stream bit 7 drives `cfg_d[0]` and bit 0 drives `cfg_d[7]`, while `cfg_d[15:8]` is zero.
- R8: In 16-bit mode the earlier byte of each pair goes bit-reversed onto `cfg_d[15:8]` and the later byte goes bit-reversed onto `cfg_d[7:0]`. An odd trailing byte leaves `cfg_d[7:0]` zero. The block takes exactly `byte_count` bytes, and a count of zero sends no words.
- R9: If `cfg_init_n` reads low after the last word, the run ends with `fail` and `fail_code` = 2, with no trailing pulses.
- R10: `cfg_done` is sampled once per system clock, up to 10000 times. A high value on the last allowed sample still counts. If no sample is high, the run ends with `fail` and `fail_code` = 3.
- R11: Once done is seen, exactly eight more `cfg_cclk` pulses are issued, and then `ok` is raised.
- R12: `busy` is high from the cycle after an accepted start until the outcome appears. The outcome holds until the next start, and at the end `cfg_cs_n` and `cfg_rdwr_n` return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| width_sel | input | 2 | Bytes per bus word: 1 or 2 |
| byte_count | input | LEN_W | Payload length in bytes |
| hold_cycles | input | HOLD_W | Program line low time in clocks (0 acts as 1) |
| phase_cycles | input | PHASE_W | Clock high/low phase length in clocks (0 acts as 1) |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | BYTE_W | Payload byte |
| s_ready | output | 1 | Block accepts the payload byte |
| cfg_prog_n | output | 1 | Target program/reset line, active low |
| cfg_cs_n | output | 1 | Target chip select, active low |
| cfg_rdwr_n | output | 1 | Target direction, low means write |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_d | output | 2*BYTE_W | Configuration data bus |
| cfg_init_n | input | 1 | Target init status, low means busy or error |
| cfg_done | input | 1 | Target done status |
| busy | output | 1 | Run in progress |
| ok | output | 1 | Last run succeeded |
| fail | output | 1 | Last run failed |
| fail_code | output | 2 | 1 bad width, 2 init error, 3 done timeout |

## Verification
Two things can land in the same cycle: the done line arriving, and the poll limit expiring. The bench measures its delay from the rise of the last data clock pulse. It raises done so that it is seen on exactly the final allowed sample, which must end in success with eight trailing pulses. It repeats the run with done raised one clock later, which must end in a timeout with no trailing pulses. Around this corner, a sweep over both widths, several lengths (odd, even and zero), phase lengths and hold times compares every captured bus word against bit-reversed stream bytes computed in the bench.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_PROG,
        S_WAIT_INIT,
        S_FETCH,
        S_LAUNCH,
        S_CLOCK,
        S_CHECK,
        S_POLL,
        S_TAIL_LAUNCH,
        S_TAIL_WAIT
    } pcfg_state_e;

    localparam logic [1:0] WSEL_8  = 2'd1;
    localparam logic [1:0] WSEL_16 = 2'd2;

    localparam logic [1:0] FAIL_NONE  = 2'd0;
    localparam logic [1:0] FAIL_WIDTH = 2'd1;
    localparam logic [1:0] FAIL_INIT  = 2'd2;
    localparam logic [1:0] FAIL_DONE  = 2'd3;

endpackage

// File: rtl/pcfg_sync.sv
module pcfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end else begin : g_single
            always_comb sh_d = d;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pcfg_cclk_gen.sv
module pcfg_cclk_gen #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [PHASE_W-1:0] phase,
    output logic               cclk,
    output logic               done
);
    typedef enum logic [1:0] {P_IDLE, P_HIGH, P_LOW} ph_e;

    typedef struct packed {
        ph_e                st;
        logic [PHASE_W-1:0] cnt;
        logic               cclk;
    } gen_t;

    gen_t r, n;
    logic last;

    always_comb begin
        n    = r;
        last = (r.cnt == phase - PHASE_W'(1));
        done = 1'b0;
        case (r.st)
            P_IDLE: begin
                if (go) begin
                    n.st   = P_HIGH;
                    n.cnt  = '0;
                    n.cclk = 1'b1;
                end
            end
            P_HIGH: begin
                if (last) begin
                    n.st   = P_LOW;
                    n.cnt  = '0;
                    n.cclk = 1'b0;
                end else begin
                    n.cnt = r.cnt + PHASE_W'(1);
                end
            end
            P_LOW: begin
                if (last) begin
                    n.st  = P_IDLE;
                    n.cnt = '0;
                    done  = 1'b1;
                end else begin
                    n.cnt = r.cnt + PHASE_W'(1);
                end
            end
            default: n.st = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= n;
    end

    assign cclk = r.cclk;
endmodule

// File: rtl/pcfg_packer.sv
module pcfg_packer #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                load,
    input  logic                wide,
    input  logic                slot,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic [2*BYTE_W-1:0] word
);
    localparam int BUS_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] rev;
    logic [BUS_W-1:0]  word_d, word_q;

    generate
        for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
            assign rev[i] = byte_in[BYTE_W-1-i];
        end
    endgenerate

    always_comb begin
        word_d = word_q;
        if (clr) begin
            word_d = '0;
        end else if (load) begin
            if (wide && !slot) word_d[BUS_W-1:BYTE_W] = rev;
            else               word_d[BYTE_W-1:0]     = rev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;
endmodule

// File: rtl/pcfg_master.sv
module pcfg_master
    import pcfg_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int LEN_W       = 16,
    parameter int HOLD_W      = 24,
    parameter int PHASE_W     = 8,
    parameter int DONE_POLLS  = 10000,
    parameter int TAIL_PULSES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          width_sel,
    input  logic [LEN_W-1:0]    byte_count,
    input  logic [HOLD_W-1:0]   hold_cycles,
    input  logic [PHASE_W-1:0]  phase_cycles,
    input  logic                s_valid,
    input  logic [BYTE_W-1:0]   s_data,
    output logic                s_ready,
    output logic                cfg_prog_n,
    output logic                cfg_cs_n,
    output logic                cfg_rdwr_n,
    output logic                cfg_cclk,
    output logic [2*BYTE_W-1:0] cfg_d,
    input  logic                cfg_init_n,
    input  logic                cfg_done,
    output logic                busy,
    output logic                ok,
    output logic                fail,
    output logic [1:0]          fail_code
);
    localparam int BUS_W  = 2 * BYTE_W;
    localparam int POLL_W = $clog2(DONE_POLLS + 1);
    localparam int CNT_W  = (HOLD_W > POLL_W) ? HOLD_W : POLL_W;
    localparam int TAIL_W = $clog2(TAIL_PULSES + 1);
    localparam int SETTLE = SYNC_STAGES + 1;

    typedef struct packed {
        pcfg_state_e        state;
        logic [LEN_W-1:0]   remain;
        logic [CNT_W-1:0]   cnt;
        logic [TAIL_W-1:0]  tail;
        logic               slot;
        logic               wide;
        logic [PHASE_W-1:0] phase;
        logic [HOLD_W-1:0]  hold;
        logic               ok;
        logic               fail;
        logic [1:0]         code;
        logic               cs_n;
        logic               rdwr_n;
        logic               prog_n;
    } ctl_t;

    ctl_t r, n;

    logic init_s, done_s;
    logic cg_go, cg_done;
    logic pk_clr, pk_load;

    pcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_init (
        .clk(clk), .rst_n(rst_n), .d(cfg_init_n), .q(init_s)
    );

    pcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
        .clk(clk), .rst_n(rst_n), .d(cfg_done), .q(done_s)
    );

    pcfg_cclk_gen #(.PHASE_W(PHASE_W)) u_cclk (
        .clk(clk), .rst_n(rst_n), .go(cg_go), .phase(r.phase),
        .cclk(cfg_cclk), .done(cg_done)
    );

    pcfg_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .load(pk_load),
        .wide(r.wide), .slot(r.slot), .byte_in(s_data), .word(cfg_d)
    );

    always_comb begin
        n       = r;
        cg_go   = 1'b0;
        pk_clr  = 1'b0;
        pk_load = 1'b0;
        s_ready = 1'b0;
        case (r.state)
            S_IDLE: begin
                if (start) begin
                    n.ok   = 1'b0;
                    n.fail = 1'b0;
                    n.code = FAIL_NONE;
                    if (width_sel == WSEL_8 || width_sel == WSEL_16) begin
                        n.wide   = (width_sel == WSEL_16);
                        n.remain = byte_count;
                        n.phase  = (phase_cycles == '0) ? PHASE_W'(1) : phase_cycles;
                        n.hold   = (hold_cycles == '0) ? HOLD_W'(1) : hold_cycles;
                        n.slot   = 1'b0;
                        n.state  = S_SETUP;
                        pk_clr   = 1'b1;
                    end else begin
                        n.fail = 1'b1;
                        n.code = FAIL_WIDTH;
                    end
                end
            end
            S_SETUP: begin
                n.cnt   = '0;
                n.state = S_PROG;
            end
            S_PROG: begin
                if (r.cnt == CNT_W'(r.hold) - CNT_W'(1)) begin
                    n.cnt   = '0;
                    n.state = S_WAIT_INIT;
                end else begin
                    n.cnt = r.cnt + CNT_W'(1);
                end
            end
            S_WAIT_INIT: begin
                if (r.cnt < CNT_W'(SETTLE)) begin
                    n.cnt = r.cnt + CNT_W'(1);
                end else if (init_s) begin
                    n.cnt   = '0;
                    n.slot  = 1'b0;
                    n.state = (r.remain == '0) ? S_CHECK : S_FETCH;
                end
            end
            S_FETCH: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    pk_load  = 1'b1;
                    n.remain = r.remain - LEN_W'(1);
                    if (!r.wide || r.slot || r.remain == LEN_W'(1)) begin
                        n.slot  = 1'b0;
                        n.state = S_LAUNCH;
                    end else begin
                        n.slot = 1'b1;
                    end
                end
            end
            S_LAUNCH: begin
                cg_go   = 1'b1;
                n.state = S_CLOCK;
            end
            S_CLOCK: begin
                if (cg_done) begin
                    pk_clr  = 1'b1;
                    n.state = (r.remain == '0) ? S_CHECK : S_FETCH;
                end
            end
            S_CHECK: begin
                if (!init_s) begin
                    n.fail  = 1'b1;
                    n.code  = FAIL_INIT;
                    n.state = S_IDLE;
                end else begin
                    n.cnt   = '0;
                    n.state = S_POLL;
                end
            end
            S_POLL: begin
                if (done_s) begin
                    n.tail  = '0;
                    n.state = S_TAIL_LAUNCH;
                end else if (r.cnt == CNT_W'(DONE_POLLS - 1)) begin
                    n.fail  = 1'b1;
                    n.code  = FAIL_DONE;
                    n.state = S_IDLE;
                end else begin
                    n.cnt = r.cnt + CNT_W'(1);
                end
            end
            S_TAIL_LAUNCH: begin
                cg_go   = 1'b1;
                n.state = S_TAIL_WAIT;
            end
            S_TAIL_WAIT: begin
                if (cg_done) begin
                    if (r.tail == TAIL_W'(TAIL_PULSES - 1)) begin
                        n.ok    = 1'b1;
                        n.state = S_IDLE;
                    end else begin
                        n.tail  = r.tail + TAIL_W'(1);
                        n.state = S_TAIL_LAUNCH;
                    end
                end
            end
            default: n.state = S_IDLE;
        endcase
        n.cs_n   = (n.state == S_IDLE);
        n.rdwr_n = (n.state == S_IDLE);
        n.prog_n = (n.state != S_PROG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r        <= '0;
            r.cs_n   <= 1'b1;
            r.rdwr_n <= 1'b1;
            r.prog_n <= 1'b1;
        end else begin
            r <= n;
        end
    end

    assign cfg_prog_n = r.prog_n;
    assign cfg_cs_n   = r.cs_n;
    assign cfg_rdwr_n = r.rdwr_n;
    assign busy       = (r.state != S_IDLE);
    assign ok         = r.ok;
    assign fail       = r.fail;
    assign fail_code  = r.code;
endmodule

// File: rtl/pcfg_master_chk.sv
module pcfg_master_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       width_sel,
    input logic             s_ready,
    input logic             cfg_prog_n,
    input logic             cfg_cs_n,
    input logic             cfg_rdwr_n,
    input logic             cfg_cclk,
    input logic [BUS_W-1:0] cfg_d,
    input logic             busy,
    input logic             ok,
    input logic             fail,
    input logic [1:0]       fail_code
);
    // R2: an unsupported width fails at once and leaves the target alone
    a_r2_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !(width_sel inside {2'd1, 2'd2}))
        |=> (fail && fail_code == 2'd1 && cfg_cs_n && cfg_prog_n && !busy));

    // R3: select and write direction settle before the program pulse
    a_r3_ctl_before_prog: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_prog_n) |-> (!cfg_cs_n && !cfg_rdwr_n && !$past(cfg_cs_n)));

    // R5: nothing is clocked or taken while the target is held in reset
    a_r5_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n |-> (!cfg_cclk && !s_ready));

    // R6: bus holds still through the high phase
    a_r6_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_d));

    // R12: outcome flags are exclusive and hidden while running
    a_r12_outcome_clean: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!ok && !fail && !cfg_cs_n));

    // R9: a reason code accompanies every failure and only a failure
    a_r9_code_matches_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_code != 2'd0) == fail);
endmodule

bind pcfg_master pcfg_master_chk #(.BUS_W(BUS_W)) u_chk (.*);

// File: tb/pcfg_master_test.sv
module pcfg_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  width_sel = 2'd1;
    logic [15:0] byte_count = '0;
    logic [23:0] hold_cycles = '0;
    logic [7:0]  phase_cycles = '0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready;
    logic        cfg_prog_n, cfg_cs_n, cfg_rdwr_n, cfg_cclk;
    logic [15:0] cfg_d;
    logic        cfg_init_n = 1'b1;
    logic        cfg_done = 1'b0;
    logic        busy, ok, fail;
    logic [1:0]  fail_code;

    always #10 clk = ~clk;

    pcfg_master uut (.*);

    int checks = 0, failures = 0;

    // target model and observation state
    int          case_id = 0, offer = 0, mode = 0, exp_w = 0;
    int          init_dly = 5, done_delay = 20;
    int          rises, prog_falls, prog_lo_len, hi_bad, min_lo, cur_hi, cur_lo;
    int          idx, accepted, ref_cnt, init_cnt, cyc = 0;
    bit          ctl_ok, rise_early, armed, init_phase, took;
    bit          prev_cclk = 0, prev_prog = 1, prev_cs_low = 0;
    int          exp_hi = 1;
    logic [15:0] cap [0:31];

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = b[7-i];
        return o;
    endfunction

    function automatic logic [7:0] byte_at(input int i, input int c);
        return 8'((i * 53 + c * 29 + 7) & 255);
    endfunction

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model of the target plus stream source, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!cfg_prog_n) begin
                if (prev_prog) begin
                    prog_falls++;
                    ctl_ok = !cfg_cs_n && !cfg_rdwr_n && prev_cs_low;
                end
                prog_lo_len++;
                cfg_init_n = 1'b0;
                cfg_done   = 1'b0;
                init_phase = 1'b1;
                init_cnt   = 0;
            end else if (init_phase) begin
                init_cnt++;
                if (init_cnt >= init_dly) begin
                    cfg_init_n = 1'b1;
                    init_phase = 1'b0;
                    if (exp_w == 0) begin armed = 1'b1; ref_cnt = 0; end
                end
            end
            if (cfg_cclk && !prev_cclk) begin
                if (!cfg_init_n || !cfg_prog_n) rise_early = 1'b1;
                if (rises < 32) cap[rises] = cfg_d;
                if (rises > 0 && cur_lo < min_lo) min_lo = cur_lo;
                rises++;
                cur_hi = 1;
                if (rises == exp_w) begin
                    if (mode == 1) cfg_init_n = 1'b0;
                    else begin armed = 1'b1; ref_cnt = 0; end
                end
            end else if (cfg_cclk) begin
                cur_hi++;
            end
            if (!cfg_cclk && prev_cclk) begin
                if (cur_hi != exp_hi) hi_bad++;
                cur_lo = 1;
            end else if (!cfg_cclk) begin
                cur_lo++;
            end
            if (armed) begin
                if (ref_cnt == done_delay && mode == 0) begin
                    cfg_done = 1'b1;
                    armed    = 1'b0;
                end
                ref_cnt++;
            end
            if (took) begin idx++; accepted++; end
            s_valid = (idx < offer) && ((cyc % 7) != 4);
            s_data  = byte_at(idx, case_id);
            took    = s_valid && s_ready;
            prev_cclk   = cfg_cclk;
            prev_prog   = cfg_prog_n;
            prev_cs_low = !cfg_cs_n;
        end
    end

    task automatic prep(input int cid, input int cnt, input int md, input int w,
                        input int pe, input int idly, input int dd);
        @(posedge clk); #1;
        case_id = cid; offer = cnt + 3; mode = md; exp_w = w; exp_hi = pe;
        init_dly = idly; done_delay = dd;
        rises = 0; prog_falls = 0; prog_lo_len = 0; hi_bad = 0; min_lo = 100000;
        cur_hi = 0; cur_lo = 0; idx = 0; accepted = 0; ref_cnt = 0; init_cnt = 0;
        ctl_ok = 0; rise_early = 0; armed = 0; init_phase = 0; took = 0;
        s_valid = 1'b0;
        for (int i = 0; i < 32; i++) cap[i] = 'x;
    endtask

    // exp_code 0 means success is expected
    task automatic run_case(input int cid, input int wsel, input int cnt, input int ph,
                            input int hd, input int md, input int dd, input int idly,
                            input int exp_code);
        int pe, he, w, n;
        logic [15:0] ew;
        pe = (ph == 0) ? 1 : ph;
        he = (hd == 0) ? 1 : hd;
        w  = (wsel == 1) ? cnt : (cnt + 1) / 2;
        prep(cid, cnt, md, w, pe, idly, dd);
        width_sel = 2'(wsel); byte_count = 16'(cnt);
        hold_cycles = 24'(hd); phase_cycles = 8'(ph);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(busy && !ok && !fail, "R12 busy after start", busy, 1);
        n = 0;
        do begin @(negedge clk); n++; end while (busy && n < 30000);
        chk(ok == (exp_code == 0), "R11/R10 ok flag", ok, exp_code == 0);
        chk(int'(fail_code) == exp_code, "R9/R10 fail code", fail_code, exp_code);
        chk(rises == w + ((exp_code == 0) ? 8 : 0), "R11/R6 pulse count", rises,
            w + ((exp_code == 0) ? 8 : 0));
        for (int i = 0; i < w; i++) begin
            if (wsel == 1) ew = {8'h00, rev8(byte_at(i, cid))};
            else ew = {rev8(byte_at(2*i, cid)),
                       (2*i+1 < cnt) ? rev8(byte_at(2*i+1, cid)) : 8'h00};
            chk(cap[i] === ew, (wsel == 1) ? "R7 word" : "R8 word", cap[i], ew);
        end
        chk(hi_bad == 0, "R6 high phase length", hi_bad, 0);
        if (rises > 1) chk(min_lo >= pe, "R6 low phase length", min_lo, pe);
        chk(prog_falls == 1 && ctl_ok, "R3 select before program pulse", ctl_ok, 1);
        chk(prog_lo_len == he, "R4 program low time", prog_lo_len, he);
        chk(!rise_early, "R5 clock before init", rise_early, 0);
        chk(accepted == cnt, "R8 bytes taken", accepted, cnt);
        repeat (4) @(negedge clk);
        chk(cfg_cs_n && cfg_rdwr_n && cfg_prog_n && !busy, "R12 lines released", cfg_cs_n, 1);
        chk(ok == (exp_code == 0) && int'(fail_code) == exp_code, "R12 outcome held", ok,
            exp_code == 0);
    endtask

    task automatic bad_width(input int cid, input int wsel);
        prep(cid, 4, 0, 0, 1, 5, 20);
        width_sel = 2'(wsel); byte_count = 16'd4;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(fail && fail_code == 2'd1 && !busy, "R2 bad width code", fail_code, 1);
        repeat (12) @(negedge clk);
        chk(prog_falls == 0 && cfg_cs_n && rises == 0, "R2 target untouched", prog_falls, 0);
        chk(accepted == 0, "R2 no bytes taken", accepted, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !ok && !fail && fail_code == 2'd0 && !s_ready, "R1 reset status", busy, 0);
        chk(cfg_prog_n && cfg_cs_n && cfg_rdwr_n && !cfg_cclk && cfg_d == '0,
            "R1 reset lines", cfg_cs_n, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        bad_width(100, 0);
        bad_width(101, 3);
        begin
            int cid = 0;
            for (int ws = 1; ws <= 2; ws++)
                for (int ci = 0; ci < 5; ci++)
                    for (int pi = 0; pi < 3; pi++) begin
                        int cnt, ph;
                        cnt = (ci == 4) ? 5 : ci;
                        ph  = (pi == 2) ? 3 : pi;
                        run_case(cid, ws, cnt, ph, (cid % 3 == 2) ? 5 : cid % 3,
                                 0, 20, 3 + (cid % 4) * 10, 0);
                        cid++;
                    end
        end
        // R9: init drops after the last word
        run_case(40, 2, 3, 2, 4, 1, 20, 6, 2);
        // R10: done never rises
        run_case(41, 1, 2, 1, 3, 2, 20, 6, 3);
        // R10: done seen on the final allowed sample, then one clock too late
        run_case(42, 1, 2, 2, 3, 0, 2 * 2 + 9998, 6, 0);
        run_case(43, 1, 2, 2, 3, 0, 2 * 2 + 9999, 6, 3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule